// File: doc/BRIEF.md
# Descriptor-Driven Memory Copy Channel

This block is one copy channel of a DMA-style co-processor. Software places an eight-word descriptor in memory and writes its address into the command-pointer register. It then adds to the channel's job counter to start work. While the channel is enabled, the counter is nonzero and a command pointer is armed, the channel does the following:

- fetches the descriptor through a word-wide memory master port;
- moves the requested number of bytes from source to destination, one word per handshake;
- writes a status word back into the descriptor's last word;
- optionally raises its interrupt flag.

A descriptor may ask for the counter to be decremented when it finishes. It may also ask the channel to continue with the descriptor at its next pointer.

The memory port is a single-phase valid/ready channel. The channel drives `mem_valid` with address, direction and write data. A transfer happens on a rising clock edge where `mem_valid` and `mem_ready` are both high. While `mem_ready` is low, the request and all its fields stay unchanged. For reads, `mem_rdata` and `mem_err` are sampled in the handshake cycle. For writes, `mem_err` is sampled in the handshake cycle. The register port is a plain write strobe with a combinational read.

Top module: `desc_copy_channel`

Register map (word index on `reg_addr`):
- 0 control: bit 0 enables the channel, bit 1 enables the interrupt.
- 1 flag: bit 0 is the interrupt flag.
- 2 flag clear: writing 1 to bit 0 clears the flag; reads as 0.
- 3 command pointer.
- 4 job counter: a write adds bits 7:0; a read returns the value in bits 23:16.

Descriptor layout, by byte offset from its address:
- +0 next pointer
- +4 control word
- +8 spare
- +12 source address
- +16 destination address
- +20 byte count
- +24 payload pointer, unused
- +28 status

Control word bits: bit 0 interrupt on completion, bit 1 decrement the counter, bit 2 chain, bit 4 memory copy.

## Requirements
- R1: After reset, every register reads 0, `irq` is low and `mem_valid` is low.
- R2: A write to register 4 adds its bits 7:0 to the job counter. The sum saturates at 255, and the counter reads back in bits 23:16.
- R3: A descriptor fetch starts only when all three hold: control bit 0 is set, the job counter is nonzero, and the command pointer has been written since the channel last stopped.
- R4: The descriptor's words 0 to 5 are read from its address upward. The status word is written at address +28 and is the last write made for that descriptor.
- R5: A copy reads the source word at offset k, then writes it to the destination at offset k, for k = 0, 4, … up to the byte count. A pending request holds its address, direction and data stable while `mem_ready` is low.
- R6: On success, the status word is 0x0000_0001. With control bit 1 set, the job counter is decremented, never below 0. A byte count of 0 makes no data access.
- R7: When a successful descriptor has control bit 2 set and a nonzero next pointer, the command pointer becomes the next pointer and processing continues while the counter is nonzero. Without the chain bit, the channel stops until the command pointer is written again.
- R8: When control bit 2 is set with a zero next pointer, the status is 0x0001_0004. No data moves, no further memory access follows, and the counter is not decremented.
- R9: When control bit 4 is clear, the status is 0x0005_0004 and no data moves.
- R10: A bus error ends the descriptor and stops the channel, leaving the counter unchanged. The status word reports which access failed:

  | Failing access | Status word |
  |---|---|
  | Source read | 0x0000_0010 |
  | Destination write | 0x0000_0020 |
  | Descriptor fetch | 0x0000_0008 |

- R11: The interrupt flag is set after any error status, and after a successful descriptor with control bit 0 set. Writing 1 to bit 0 of register 2 clears it; a set in the same cycle wins.
- R12: `irq` is high exactly when the flag is set and control bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the handshake cycle |
| mem_err | input | 1 | Bus error for the access in the handshake cycle |
| irq | output | 1 | Channel interrupt |

## Verification
The hardest conditions to reach are a bus error in the middle of a copy and the silence the channel must keep after a chain request with a zero next pointer. Both depend on how far the channel has got through the descriptor when the error arrives. The memory model in the bench therefore answers with an error for one chosen address, placed at the second source word, the first destination word or the third descriptor word. It also withholds `mem_ready` in a pseudo-random pattern throughout, so every request is held for varying stretches. A scoreboard holds the ordered list of writes each descriptor should make. After an error, the bench leaves the counter nonzero and the channel enabled, then counts handshakes over a further window to show that no access follows.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int WORD_W      = 32;
  localparam int FETCH_WORDS = 6;
  localparam int STATUS_IDX  = 7;

  // control word bits
  localparam int C0_IRQ   = 0;
  localparam int C0_DEC   = 1;
  localparam int C0_CHAIN = 2;
  localparam int C0_COPY  = 4;

  // status word fields
  localparam int ST_DONE     = 0;
  localparam int ST_SETUP    = 2;
  localparam int ST_PKT      = 3;
  localparam int ST_SRC      = 4;
  localparam int ST_DST      = 5;
  localparam int ST_CODE_LSB = 16;
  localparam logic [7:0] CODE_CHAIN0 = 8'd1;
  localparam logic [7:0] CODE_MODE   = 8'd5;

  // register word indices
  localparam int REG_CTRL = 0;
  localparam int REG_FLAG = 1;
  localparam int REG_CLR  = 2;
  localparam int REG_CMD  = 3;
  localparam int REG_SEMA = 4;
  localparam int SEMA_VAL_LSB = 16;

  typedef enum logic [2:0] {
    ENG_IDLE, ENG_FETCH, ENG_DECODE, ENG_READ, ENG_WRITE, ENG_STATUS
  } eng_state_e;
endpackage

// File: rtl/dcc_engine.sv
module dcc_engine
  import dcc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [AW-1:0]     base_addr,
  output logic              busy,
  output logic              fin,
  output logic              fin_ok,
  output logic              fin_dec,
  output logic              fin_irq,
  output logic              fin_chain,
  output logic [AW-1:0]     fin_next,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_err
);
  localparam int IDX_W = $clog2(FETCH_WORDS);
  localparam logic [AW-1:0] STAT_OFS = AW'(STATUS_IDX * 4);
  localparam logic [AW-1:0] STEP     = AW'(4);

  eng_state_e        st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [AW-1:0]     base_q, next_q, src_q, dst_q, cnt_q, off_q;
  logic              c0_irq_q, c0_dec_q, c0_chain_q, c0_copy_q;
  logic [WORD_W-1:0] buf_q, stat_q;
  logic              hs;

  always_comb begin
    mem_valid = (st_q == ENG_FETCH) || (st_q == ENG_READ) ||
                (st_q == ENG_WRITE) || (st_q == ENG_STATUS);
    mem_write = (st_q == ENG_WRITE) || (st_q == ENG_STATUS);
    mem_wdata = (st_q == ENG_WRITE) ? buf_q : stat_q;
    case (st_q)
      ENG_FETCH: mem_addr = base_q + {{(AW-IDX_W-2){1'b0}}, idx_q, 2'b00};
      ENG_READ:  mem_addr = src_q + off_q;
      ENG_WRITE: mem_addr = dst_q + off_q;
      default:   mem_addr = base_q + STAT_OFS;
    endcase
  end

  assign hs        = mem_valid && mem_ready;
  assign busy      = (st_q != ENG_IDLE);
  assign fin       = (st_q == ENG_STATUS) && hs;
  assign fin_ok    = stat_q[ST_DONE];
  assign fin_dec   = c0_dec_q;
  assign fin_irq   = c0_irq_q;
  assign fin_chain = c0_chain_q;
  assign fin_next  = next_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ENG_IDLE;
      idx_q      <= '0;
      base_q     <= '0;
      next_q     <= '0;
      src_q      <= '0;
      dst_q      <= '0;
      cnt_q      <= '0;
      off_q      <= '0;
      c0_irq_q   <= 1'b0;
      c0_dec_q   <= 1'b0;
      c0_chain_q <= 1'b0;
      c0_copy_q  <= 1'b0;
      buf_q      <= '0;
      stat_q     <= '0;
    end else begin
      case (st_q)
        ENG_IDLE: begin
          if (go) begin
            base_q <= base_addr;
            idx_q  <= '0;
            st_q   <= ENG_FETCH;
          end
        end
        ENG_FETCH: begin
          if (hs) begin
            if (mem_err) begin
              stat_q <= WORD_W'(1) << ST_PKT;
              st_q   <= ENG_STATUS;
            end else begin
              case (idx_q)
                IDX_W'(0): next_q <= AW'(mem_rdata);
                IDX_W'(1): begin
                  c0_irq_q   <= mem_rdata[C0_IRQ];
                  c0_dec_q   <= mem_rdata[C0_DEC];
                  c0_chain_q <= mem_rdata[C0_CHAIN];
                  c0_copy_q  <= mem_rdata[C0_COPY];
                end
                IDX_W'(3): src_q <= AW'(mem_rdata);
                IDX_W'(4): dst_q <= AW'(mem_rdata);
                IDX_W'(5): cnt_q <= AW'(mem_rdata);
                default: ;
              endcase
              if (idx_q == IDX_W'(FETCH_WORDS - 1)) st_q <= ENG_DECODE;
              else idx_q <= idx_q + 1'b1;
            end
          end
        end
        ENG_DECODE: begin
          off_q <= '0;
          if (c0_chain_q && (next_q == '0)) begin
            stat_q <= (WORD_W'(CODE_CHAIN0) << ST_CODE_LSB) | (WORD_W'(1) << ST_SETUP);
            st_q   <= ENG_STATUS;
          end else if (!c0_copy_q) begin
            stat_q <= (WORD_W'(CODE_MODE) << ST_CODE_LSB) | (WORD_W'(1) << ST_SETUP);
            st_q   <= ENG_STATUS;
          end else if (cnt_q == '0) begin
            stat_q <= WORD_W'(1) << ST_DONE;
            st_q   <= ENG_STATUS;
          end else begin
            st_q <= ENG_READ;
          end
        end
        ENG_READ: begin
          if (hs) begin
            if (mem_err) begin
              stat_q <= WORD_W'(1) << ST_SRC;
              st_q   <= ENG_STATUS;
            end else begin
              buf_q <= mem_rdata;
              st_q  <= ENG_WRITE;
            end
          end
        end
        ENG_WRITE: begin
          if (hs) begin
            if (mem_err) begin
              stat_q <= WORD_W'(1) << ST_DST;
              st_q   <= ENG_STATUS;
            end else if ((off_q + STEP) >= cnt_q) begin
              stat_q <= WORD_W'(1) << ST_DONE;
              st_q   <= ENG_STATUS;
            end else begin
              off_q <= off_q + STEP;
              st_q  <= ENG_READ;
            end
          end
        end
        ENG_STATUS: begin
          if (hs) st_q <= ENG_IDLE;
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  // R5: a pending request is held unchanged under back-pressure
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                $stable(mem_write) && $stable(mem_wdata));

  // R4: the status write closes the descriptor; nothing is issued right after it
  assert_status_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !mem_valid);

  // R8: chain with a zero next pointer goes straight to the status write
  assert_chain_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_DECODE) && c0_chain_q && (next_q == '0) |=>
      (st_q == ENG_STATUS) && (stat_q[ST_CODE_LSB +: 8] == CODE_CHAIN0));
endmodule

// File: rtl/dcc_regs.sv
module dcc_regs
  import dcc_pkg::*;
#(
  parameter int AW     = 32,
  parameter int REG_AW = 3,
  parameter int SEMA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              eng_busy,
  output logic              go,
  output logic [AW-1:0]     base_addr,
  input  logic              fin,
  input  logic              fin_ok,
  input  logic              fin_dec,
  input  logic              fin_irq,
  input  logic              fin_chain,
  input  logic [AW-1:0]     fin_next,
  output logic              irq
);
  localparam logic [SEMA_W:0] SEMA_MAX = {1'b0, {SEMA_W{1'b1}}};

  logic              en_q, ie_q, flag_q, armed_q;
  logic [AW-1:0]     cmd_q;
  logic [SEMA_W-1:0] sema_q, sema_d;
  logic              wr_ctrl, wr_clr, wr_cmd, wr_sema;
  logic              flag_set, flag_clr, dec;
  logic [SEMA_W:0]   sum;

  assign wr_ctrl = reg_we && (reg_addr == REG_AW'(REG_CTRL));
  assign wr_clr  = reg_we && (reg_addr == REG_AW'(REG_CLR));
  assign wr_cmd  = reg_we && (reg_addr == REG_AW'(REG_CMD));
  assign wr_sema = reg_we && (reg_addr == REG_AW'(REG_SEMA));

  assign dec      = fin && fin_ok && fin_dec;
  assign flag_set = fin && (!fin_ok || fin_irq);
  assign flag_clr = wr_clr && reg_wdata[0];

  always_comb begin
    sum = {1'b0, sema_q} + (wr_sema ? {1'b0, reg_wdata[SEMA_W-1:0]} : '0);
    if (dec && (sum != '0)) sum = sum - 1'b1;
    sema_d = (sum > SEMA_MAX) ? SEMA_MAX[SEMA_W-1:0] : sum[SEMA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      cmd_q   <= '0;
      sema_q  <= '0;
    end else begin
      sema_q <= sema_d;
      flag_q <= flag_set | (flag_q & ~flag_clr);
      if (wr_ctrl) begin
        en_q <= reg_wdata[0];
        ie_q <= reg_wdata[1];
      end
      if (wr_cmd) begin
        cmd_q   <= AW'(reg_wdata);
        armed_q <= 1'b1;
      end else if (fin) begin
        if (fin_ok && fin_chain) cmd_q <= fin_next;
        else armed_q <= 1'b0;
      end
    end
  end

  assign go        = en_q && armed_q && (sema_q != '0) && !eng_busy;
  assign base_addr = cmd_q;
  assign irq       = flag_q && ie_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_AW'(REG_CTRL): reg_rdata[1:0] = {ie_q, en_q};
      REG_AW'(REG_FLAG): reg_rdata[0]   = flag_q;
      REG_AW'(REG_CMD):  reg_rdata      = WORD_W'(cmd_q);
      REG_AW'(REG_SEMA): reg_rdata[SEMA_VAL_LSB +: SEMA_W] = sema_q;
      default: ;
    endcase
  end

  // R2: a full counter stays full when more is added
  assert_sema_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sema_q == '1) && wr_sema && !fin |=> (sema_q == '1));

  // R11: a clear without a simultaneous completion empties the flag
  assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !fin |=> !flag_q);

  // R7: a successful chained descriptor moves the command pointer
  assert_chain_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fin && fin_ok && fin_chain && !wr_cmd |=> (cmd_q == $past(fin_next)));
endmodule

// File: rtl/desc_copy_channel.sv
module desc_copy_channel
  import dcc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 3,
  parameter int SEMA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_err,
  output logic              irq
);
  logic              go, busy, fin, fin_ok, fin_dec, fin_irq, fin_chain;
  logic [ADDR_W-1:0] base_addr, fin_next;

  dcc_regs #(.AW(ADDR_W), .REG_AW(REG_AW), .SEMA_W(SEMA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .eng_busy  (busy),
    .go        (go),
    .base_addr (base_addr),
    .fin       (fin),
    .fin_ok    (fin_ok),
    .fin_dec   (fin_dec),
    .fin_irq   (fin_irq),
    .fin_chain (fin_chain),
    .fin_next  (fin_next),
    .irq       (irq)
  );

  dcc_engine #(.AW(ADDR_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .base_addr (base_addr),
    .busy      (busy),
    .fin       (fin),
    .fin_ok    (fin_ok),
    .fin_dec   (fin_dec),
    .fin_irq   (fin_irq),
    .fin_chain (fin_chain),
    .fin_next  (fin_next),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_write (mem_write),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_err   (mem_err)
  );
endmodule

// File: tb/desc_copy_channel_tb.sv
module desc_copy_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] NO_ERR = 32'hFFFF_FFFC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_valid, mem_write, mem_ready = 1'b0, mem_err, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] mem [0:255];
  logic [31:0] err_addr = NO_ERR;
  logic [7:0]  lfsr = 8'h5A;
  int          n_checks = 0, n_err = 0, acc_cnt = 0;
  bit          done = 1'b0;
  logic [31:0] exp_addr[$];
  logic [31:0] exp_data[$];
  string       exp_req[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem[mem_addr[9:2]];
  assign mem_err   = (mem_addr == err_addr);

  desc_copy_channel u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_err(mem_err), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // memory model and scoreboard monitor
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 + 32'(i * 7);
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready = lfsr[0] | lfsr[1];
      #1;
      if (rst_n && mem_valid && mem_ready) begin
        acc_cnt++;
        if (mem_write) begin
          if (exp_addr.size() == 0) begin
            check("R5 unexpected write", mem_addr, 32'hFFFF_FFFF);
          end else begin
            check({exp_req[0], " write address"}, mem_addr, exp_addr[0]);
            check({exp_req[0], " write data"}, mem_wdata, exp_data[0]);
            void'(exp_addr.pop_front());
            void'(exp_data.pop_front());
            void'(exp_req.pop_front());
          end
          if (!mem_err) mem[mem_addr[9:2]] = mem_wdata;
        end
      end
    end
  end

  task automatic push(input logic [31:0] a, input logic [31:0] d, input string req);
    exp_addr.push_back(a);
    exp_data.push_back(d);
    exp_req.push_back(req);
  endtask

  task automatic reg_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 3'(a);
    #2 d = reg_rdata;
  endtask

  task automatic put_desc(input logic [31:0] base, input logic [31:0] nxt,
                          input logic [31:0] c0, input logic [31:0] src,
                          input logic [31:0] dst, input logic [31:0] cnt);
    mem[base[9:2]]     = nxt;
    mem[base[9:2] + 1] = c0;
    mem[base[9:2] + 2] = 32'h0;
    mem[base[9:2] + 3] = src;
    mem[base[9:2] + 4] = dst;
    mem[base[9:2] + 5] = cnt;
    mem[base[9:2] + 6] = 32'h0;
    mem[base[9:2] + 7] = 32'h0;
  endtask

  task automatic drain(input string req);
    int guard = 0;
    while (exp_addr.size() != 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (10) @(negedge clk);
    check({req, " all expected writes seen"}, 32'(exp_addr.size()), 32'h0);
  endtask

  initial begin
    logic [31:0] rd;
    int snap;
    repeat (5) @(negedge clk);
    // R1: reset state
    reg_rd(0, rd); check("R1 control", rd, 32'h0);
    reg_rd(1, rd); check("R1 flag", rd, 32'h0);
    reg_rd(3, rd); check("R1 command pointer", rd, 32'h0);
    reg_rd(4, rd); check("R1 counter", rd, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 mem_valid", {31'h0, mem_valid}, 32'h0);
    rst_n = 1'b1;

    // R3: no fetch with zero counter, nor while disabled
    reg_wr(3, 32'h040);
    reg_wr(0, 32'h3);
    snap = acc_cnt;
    repeat (20) @(negedge clk);
    check("R3 idle with counter zero", 32'(acc_cnt), 32'(snap));
    reg_wr(0, 32'h0);
    reg_wr(4, 32'h2);
    repeat (20) @(negedge clk);
    check("R3 idle while disabled", 32'(acc_cnt), 32'(snap));
    reg_rd(4, rd); check("R2 counter after add", rd, 32'h0002_0000);

    // R5 R6 R7: chained pair of copies
    put_desc(32'h040, 32'h080, 32'h17, 32'h200, 32'h300, 32'd12);
    put_desc(32'h080, 32'h000, 32'h12, 32'h240, 32'h340, 32'd8);
    for (int k = 0; k < 3; k++) push(32'h300 + 32'(4*k), mem[(32'h200 >> 2) + k], "R5 copy A");
    push(32'h05C, 32'h1, "R4 R6 status A");
    for (int k = 0; k < 2; k++) push(32'h340 + 32'(4*k), mem[(32'h240 >> 2) + k], "R5 copy B");
    push(32'h09C, 32'h1, "R4 R6 status B");
    reg_wr(0, 32'h3);
    drain("R7 chain");
    reg_rd(4, rd); check("R6 counter decremented twice", rd, 32'h0);
    reg_rd(3, rd); check("R7 command pointer follows chain", rd, 32'h080);
    reg_rd(1, rd); check("R11 flag set by completion", rd, 32'h1);
    check("R12 irq with enable", {31'h0, irq}, 32'h1);
    reg_wr(2, 32'h1);
    reg_rd(1, rd); check("R11 flag cleared", rd, 32'h0);
    check("R12 irq low after clear", {31'h0, irq}, 32'h0);

    // R8: chain requested with zero next pointer
    put_desc(32'h0C0, 32'h0, 32'h16, 32'h200, 32'h380, 32'd8);
    push(32'h0DC, 32'h0001_0004, "R8 status");
    reg_wr(4, 32'h1);
    reg_wr(3, 32'h0C0);
    drain("R8");
    snap = acc_cnt;
    repeat (30) @(negedge clk);
    check("R8 no access after error", 32'(acc_cnt), 32'(snap));
    reg_rd(4, rd); check("R8 counter kept", rd, 32'h0001_0000);
    reg_rd(1, rd); check("R11 flag set by error", rd, 32'h1);

    // R9: no operation selected, interrupt disabled
    reg_wr(2, 32'h1);
    reg_wr(0, 32'h1);
    put_desc(32'h0E0, 32'h0, 32'h02, 32'h200, 32'h380, 32'd8);
    push(32'h0FC, 32'h0005_0004, "R9 status");
    reg_wr(3, 32'h0E0);
    drain("R9");
    reg_rd(1, rd); check("R11 flag after mode error", rd, 32'h1);
    check("R12 irq masked", {31'h0, irq}, 32'h0);

    // R10: source error on second word
    reg_wr(2, 32'h1);
    reg_wr(0, 32'h3);
    err_addr = 32'h204;
    put_desc(32'h100, 32'h0, 32'h13, 32'h200, 32'h300, 32'd12);
    push(32'h300, mem[32'h200 >> 2], "R10 first word before source error");
    push(32'h11C, 32'h10, "R10 source error status");
    reg_wr(3, 32'h100);
    drain("R10 source");
    reg_rd(4, rd); check("R10 counter kept", rd, 32'h0001_0000);

    // R10: destination error on first word
    err_addr = 32'h320;
    put_desc(32'h120, 32'h0, 32'h13, 32'h210, 32'h320, 32'd8);
    push(32'h320, mem[32'h210 >> 2], "R10 failing destination write");
    push(32'h13C, 32'h20, "R10 destination error status");
    reg_wr(3, 32'h120);
    drain("R10 destination");

    // R10: fetch error on descriptor word 2
    err_addr = 32'h168;
    put_desc(32'h160, 32'h0, 32'h13, 32'h200, 32'h300, 32'd8);
    push(32'h17C, 32'h08, "R10 fetch error status");
    reg_wr(3, 32'h160);
    drain("R10 fetch");
    err_addr = NO_ERR;

    // R6: zero byte count
    reg_wr(2, 32'h1);
    put_desc(32'h140, 32'h0, 32'h13, 32'h200, 32'h300, 32'd0);
    push(32'h15C, 32'h1, "R6 zero count status");
    reg_wr(3, 32'h140);
    drain("R6 zero count");
    reg_rd(4, rd); check("R6 counter to zero", rd, 32'h0);
    reg_rd(1, rd); check("R11 flag on zero-count completion", rd, 32'h1);

    // R2: saturation
    reg_wr(0, 32'h0);
    reg_wr(4, 32'd200);
    reg_wr(4, 32'd100);
    reg_rd(4, rd); check("R2 counter saturates", rd, 32'h00FF_0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL R4 watchdog: actual 0x00000000 expected 0x00000001");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule